// File: doc/BRIEF.md
# Composited Digital Video Output Stream Generator

This block builds a byte-serial 4:2:2 digital video stream in the style of CCIR 656. The stream carries a video layer with a graphics overlay composited on top of it. The video layer reaches the block as three planar sample streams: luma, blue-difference and red-difference. The overlay reaches it as one stream of packed pixels. Each overlay pixel carries an 8-bit alpha value together with its own Y, U and V. Every input stream works in show-ahead fashion. The data is valid whenever the block looks at it, and the block pulses the stream's request for one clock to consume the current item.

Each output pixel is taken from the video layer alone, from an alpha blend of the two layers, or from a chroma-key choice between them. Before compositing, the video layer can be doubled in width by repeating its samples. The overlay always stays at full resolution. A programmable raster counter defines the line length, the active width, the frame height and the active height, and it can split each frame into two interlaced fields. The block writes the start and end timing codes with the field, vertical-blank and horizontal flags. It fills every blanking position with black-level bytes. The block emits one byte per clock.

Top module: `vid_out_compositor`

## Requirements
- R1: While rst_n is low, vout is 0x10. After release, the first four bytes are the start code of line 0 in field 0: FF 00 00 80.
- R2: A line is 2*cfg_tot_w bytes long. Byte positions 0..3 hold the start code. The next 2*cfg_act_w bytes are the active region, in the order Cb Y Cr Y. The next 4 bytes hold the end code, and the rest of the line is blanking. cfg_act_w is even, and cfg_tot_w - cfg_act_w >= 4.
- R3: Each timing code is FF 00 00 XY. XY has bit 7 = 1, bit 6 = F, bit 5 = V, bit 4 = H, bit 3 = V^H, bit 2 = F^H, bit 1 = F^V and bit 0 = F^V^H. H is 0 in the start code and 1 in the end code.
- R4: A frame has cfg_tot_l lines. In progressive mode F is 0 on every line. With cfg_ilace set, line numbers from cfg_tot_l>>1 upward carry F = 1, and line numbers in that field count from the field's first line. V is 1 when the line number within the field is at least cfg_act_l.
- R5: Every non-code byte outside the active picture is a black-level byte. Bytes at even positions in the line are 0x80 and bytes at odd positions are 0x10. This includes the active region of lines with V = 1.
- R6: Without upscaling, each Cb byte consumes one U sample, each Cr byte consumes one V sample and each luma byte consumes one Y sample. No stream is requested outside the active picture, and at most one video stream is requested in any cycle.
- R7: With cfg_upscale set, each Y sample fills two consecutive luma bytes. Each U/V pair fills two consecutive Cb-Y-Cr-Y groups, and the pair is consumed during the odd-numbered group. cfg_act_w is a multiple of 4.
- R8: In modes 1 and 2, each luma byte consumes one overlay pixel, whether or not upscaling is on. The Cb byte uses the U of the pixel that the following Y0 byte consumes, and the Cr byte uses the V of the pixel that the following Y1 byte consumes. ov_data is {alpha[31:24], Y[23:16], U[15:8], V[7:0]}.
- R9: In mode 1 (alpha), each active byte is (a*o + (256-a)*v) >> 8. Here a is the overlay alpha, o is the overlay component and v is the video component. With a = 0 the byte equals the video component.
- R10: In mode 2 (key), if the overlay pixel's Y, U and V all lie inside the inclusive ranges cfg_key_lo..cfg_key_hi (packed {Y,U,V}, 8 bits each), the byte is the video component. Otherwise it is the overlay component.
- R11: In modes 0 and 3, active bytes are the video component, and the overlay stream is never requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_act_w | input | WW | Active pixels per line |
| cfg_tot_w | input | WW | Total pixels per line |
| cfg_act_l | input | LW | Active lines per field |
| cfg_tot_l | input | LW | Lines per frame |
| cfg_ilace | input | 1 | Split the frame into two fields |
| cfg_upscale | input | 1 | Double the video layer horizontally |
| cfg_mode | input | 2 | 0 video, 1 alpha, 2 key, 3 video |
| cfg_key_lo | input | 24 | Lower key bounds {Y,U,V} |
| cfg_key_hi | input | 24 | Upper key bounds {Y,U,V} |
| y_req | output | 1 | Consume the current luma sample |
| y_data | input | 8 | Current luma sample |
| u_req | output | 1 | Consume the current U sample |
| u_data | input | 8 | Current U sample |
| v_req | output | 1 | Consume the current V sample |
| v_data | input | 8 | Current V sample |
| ov_req | output | 1 | Consume the current overlay pixel |
| ov_data | input | 32 | Current overlay pixel {alpha,Y,U,V} |
| vout | output | 8 | Output byte stream |

## Verification
The hardest case to reach is the second field of an interlaced frame while upscaling is on. There the line number inside the field has to be rebased, and chroma is consumed only on every other sample group. A slip in either of these shows up only after many lines. The stimulus uses a tiny raster with an odd line count and an active height shorter than each field, so a few hundred clocks cover both fields twice. Every source value is a distinct function of its consumption index, so a sample taken one step early or late changes the compared byte.

// File: rtl/vo_pkg.sv
package vo_pkg;
  typedef enum logic [1:0] {
    MIX_OFF   = 2'd0,
    MIX_ALPHA = 2'd1,
    MIX_KEY   = 2'd2,
    MIX_RSVD  = 2'd3
  } mix_mode_e;

  typedef enum logic [1:0] {
    SEG_SAV,
    SEG_ACT,
    SEG_EAV,
    SEG_BLANK
  } seg_e;

  localparam logic [7:0] LVL_CHROMA = 8'h80;
  localparam logic [7:0] LVL_LUMA   = 8'h10;

  // flag byte of a timing code with its protection bits
  function automatic logic [7:0] code_flags(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction
endpackage

// File: rtl/vo_raster.sv
module vo_raster
  import vo_pkg::*;
#(
  parameter int WW = 12,
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [WW-1:0] tot_w,
  input  logic [WW-1:0] act_w,
  input  logic [LW-1:0] tot_l,
  input  logic [LW-1:0] act_l,
  input  logic          ilace,
  output seg_e          seg,
  output logic [1:0]    cidx,
  output logic [WW:0]   apos,
  output logic          hodd,
  output logic          fld,
  output logic          vbl
);
  localparam int HW = WW + 1;

  logic [HW-1:0] hc_q, hc_d;
  logic [LW-1:0] vc_q, vc_d;
  logic [HW-1:0] line_end, act_end, eav_end, eoff;
  logic [LW-1:0] half, lin_f;

  // next state and decode
  always_comb begin
    line_end = {tot_w, 1'b0} - HW'(1);
    act_end  = HW'(4) + {act_w, 1'b0};
    eav_end  = act_end + HW'(4);
    eoff     = hc_q - act_end;
    if (hc_q < HW'(4))         seg = SEG_SAV;
    else if (hc_q < act_end)   seg = SEG_ACT;
    else if (hc_q < eav_end)   seg = SEG_EAV;
    else                       seg = SEG_BLANK;
    cidx  = (seg == SEG_SAV) ? hc_q[1:0] : eoff[1:0];
    apos  = hc_q - HW'(4);
    hodd  = hc_q[0];
    half  = tot_l >> 1;
    fld   = ilace && (vc_q >= half);
    lin_f = fld ? (vc_q - half) : vc_q;
    vbl   = (lin_f >= act_l);
    hc_d  = hc_q + HW'(1);
    vc_d  = vc_q;
    if (hc_q == line_end) begin
      hc_d = '0;
      vc_d = (vc_q == tot_l - LW'(1)) ? '0 : vc_q + LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc_q <= '0;
      vc_q <= '0;
    end else begin
      hc_q <= hc_d;
      vc_q <= vc_d;
    end
  end

  p_hc_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hc_q <= line_end);
  p_vc_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vc_q < tot_l);
  p_line_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hc_q != line_end) |=> $stable(vc_q));
endmodule

// File: rtl/vo_mix.sv
module vo_mix
  import vo_pkg::*;
(
  input  mix_mode_e   mode,
  input  logic [7:0]  vid,
  input  logic [7:0]  ovc,
  input  logic [7:0]  alpha,
  input  logic [23:0] ovl_yuv,
  input  logic [23:0] key_lo,
  input  logic [23:0] key_hi,
  output logic [7:0]  pix
);
  logic [2:0]  in_rng;
  logic [16:0] mix_sum;
  logic        key_hit;

  for (genvar c = 0; c < 3; c++) begin : g_key
    assign in_rng[c] = (ovl_yuv[c*8 +: 8] >= key_lo[c*8 +: 8]) &&
                       (ovl_yuv[c*8 +: 8] <= key_hi[c*8 +: 8]);
  end

  always_comb begin
    key_hit = &in_rng;
    mix_sum = 17'(alpha) * 17'(ovc) + (17'd256 - 17'(alpha)) * 17'(vid);
    case (mode)
      MIX_ALPHA: pix = mix_sum[15:8];
      MIX_KEY:   pix = key_hit ? vid : ovc;
      default:   pix = vid;
    endcase
  end
endmodule

// File: rtl/vid_out_compositor.sv
module vid_out_compositor
  import vo_pkg::*;
#(
  parameter int WW = 12,
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [WW-1:0] cfg_act_w,
  input  logic [WW-1:0] cfg_tot_w,
  input  logic [LW-1:0] cfg_act_l,
  input  logic [LW-1:0] cfg_tot_l,
  input  logic          cfg_ilace,
  input  logic          cfg_upscale,
  input  logic [1:0]    cfg_mode,
  input  logic [23:0]   cfg_key_lo,
  input  logic [23:0]   cfg_key_hi,
  output logic          y_req,
  input  logic [7:0]    y_data,
  output logic          u_req,
  input  logic [7:0]    u_data,
  output logic          v_req,
  input  logic [7:0]    v_data,
  output logic          ov_req,
  input  logic [31:0]   ov_data,
  output logic [7:0]    vout
);
  seg_e        seg;
  logic [1:0]  cidx, phase;
  logic [WW:0] apos;
  logic        hodd, fld, vbl, act_vid, pair_odd, ovl_on;
  logic [7:0]  vid_b, ovc_b, mix_b, out_d, vout_q, blank_b;
  mix_mode_e   mode;

  assign mode = mix_mode_e'(cfg_mode);

  vo_raster #(.WW(WW), .LW(LW)) u_raster (
    .clk   (clk),
    .rst_n (rst_n),
    .tot_w (cfg_tot_w),
    .act_w (cfg_act_w),
    .tot_l (cfg_tot_l),
    .act_l (cfg_act_l),
    .ilace (cfg_ilace),
    .seg   (seg),
    .cidx  (cidx),
    .apos  (apos),
    .hodd  (hodd),
    .fld   (fld),
    .vbl   (vbl)
  );

  // stream consumption
  always_comb begin
    act_vid  = (seg == SEG_ACT) && !vbl;
    phase    = apos[1:0];
    pair_odd = apos[2];
    ovl_on   = (mode == MIX_ALPHA) || (mode == MIX_KEY);
    y_req    = act_vid && phase[0] && (!cfg_upscale || phase == 2'd3);
    u_req    = act_vid && (phase == 2'd0) && (!cfg_upscale || pair_odd);
    v_req    = act_vid && (phase == 2'd2) && (!cfg_upscale || pair_odd);
    ov_req   = act_vid && phase[0] && ovl_on;
    case (phase)
      2'd0:    begin vid_b = u_data; ovc_b = ov_data[15:8];  end
      2'd2:    begin vid_b = v_data; ovc_b = ov_data[7:0];   end
      default: begin vid_b = y_data; ovc_b = ov_data[23:16]; end
    endcase
  end

  vo_mix u_mix (
    .mode    (mode),
    .vid     (vid_b),
    .ovc     (ovc_b),
    .alpha   (ov_data[31:24]),
    .ovl_yuv (ov_data[23:0]),
    .key_lo  (cfg_key_lo),
    .key_hi  (cfg_key_hi),
    .pix     (mix_b)
  );

  // output byte selection
  always_comb begin
    blank_b = hodd ? LVL_LUMA : LVL_CHROMA;
    case (seg)
      SEG_SAV, SEG_EAV: begin
        case (cidx)
          2'd0:    out_d = 8'hFF;
          2'd3:    out_d = code_flags(fld, vbl, seg == SEG_EAV);
          default: out_d = 8'h00;
        endcase
      end
      SEG_ACT: out_d = act_vid ? mix_b : blank_b;
      default: out_d = blank_b;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vout_q <= LVL_LUMA;
    else        vout_q <= out_d;
  end

  assign vout = vout_q;

  p_code_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((seg == SEG_SAV || seg == SEG_EAV) && cidx == 2'd0) |=> (vout == 8'hFF));
  p_blank_lvl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (seg == SEG_BLANK) |=> (vout == LVL_CHROMA || vout == LVL_LUMA));
  p_vid_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({y_req, u_req, v_req}));
  p_idle_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !act_vid |-> !(y_req || u_req || v_req || ov_req));
  p_up_luma_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_upscale && y_req) |-> (phase == 2'd3));
  p_ovl_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd0 || cfg_mode == 2'd3) |-> !ov_req);
  p_alpha_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (act_vid && cfg_mode == 2'd1 && ov_data[31:24] == 8'd0) |=> (vout == $past(vid_b)));
endmodule

// File: tb/vid_out_compositor_test.sv
module vid_out_compositor_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] cfg_act_w = 12'd4, cfg_tot_w = 12'd10;
  logic [10:0] cfg_act_l = 11'd2, cfg_tot_l = 11'd4;
  logic        cfg_ilace = 1'b0, cfg_upscale = 1'b0;
  logic [1:0]  cfg_mode = 2'd0;
  logic [23:0] cfg_key_lo = {8'd0, 8'd64, 8'd0};
  logic [23:0] cfg_key_hi = {8'd127, 8'd255, 8'd200};
  logic        y_req, u_req, v_req, ov_req;
  logic [7:0]  y_data, u_data, v_data, vout;
  logic [31:0] ov_data;
  int yi, ui, vi, oi;
  int checks = 0, fails = 0;
  logic [7:0] qe[$];
  string      qr[$];

  always #2 clk = ~clk;

  vid_out_compositor uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_act_w(cfg_act_w), .cfg_tot_w(cfg_tot_w),
    .cfg_act_l(cfg_act_l), .cfg_tot_l(cfg_tot_l),
    .cfg_ilace(cfg_ilace), .cfg_upscale(cfg_upscale), .cfg_mode(cfg_mode),
    .cfg_key_lo(cfg_key_lo), .cfg_key_hi(cfg_key_hi),
    .y_req(y_req), .y_data(y_data), .u_req(u_req), .u_data(u_data),
    .v_req(v_req), .v_data(v_data), .ov_req(ov_req), .ov_data(ov_data),
    .vout(vout)
  );

  function automatic logic [7:0] yf(int i); return 8'((i * 37 + 16) & 255); endfunction
  function automatic logic [7:0] uf(int i); return 8'((i * 53 + 7) & 255); endfunction
  function automatic logic [7:0] vf(int i); return 8'((i * 29 + 100) & 255); endfunction
  function automatic logic [31:0] ovf(int i);
    int a;
    a = (i % 4 == 0) ? 0 : (i % 4 == 1) ? 255 : ((i * 67) & 255);
    return {8'(a), 8'((i * 11 + 3) & 255), 8'((i * 23 + 50) & 255), 8'((i * 41 + 9) & 255)};
  endfunction

  // show-ahead sources
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      yi <= 0; ui <= 0; vi <= 0; oi <= 0;
    end else begin
      if (y_req)  yi <= yi + 1;
      if (u_req)  ui <= ui + 1;
      if (v_req)  vi <= vi + 1;
      if (ov_req) oi <= oi + 1;
    end
  end
  assign y_data  = yf(yi);
  assign u_data  = uf(ui);
  assign v_data  = vf(vi);
  assign ov_data = ovf(oi);

  // monitor
  always @(negedge clk) begin
    if (qe.size() > 0) begin
      logic [7:0] e;
      string r;
      e = qe.pop_front();
      r = qr.pop_front();
      checks++;
      if (vout !== e) begin
        fails++;
        $display("FAIL %s stream byte actual=%h expected=%h", r, vout, e);
      end
    end
  end

  // driver: builds the expected stream from the requirements
  task automatic run_cfg(input int aw, input int tw, input int al, input int tl,
                         input logic il, input logic up, input logic [1:0] md,
                         input int frames);
    int mh, mv, my, mu, mw, mo, cyc;
    rst_n = 1'b0;
    cfg_act_w = 12'(aw); cfg_tot_w = 12'(tw);
    cfg_act_l = 11'(al); cfg_tot_l = 11'(tl);
    cfg_ilace = il; cfg_upscale = up; cfg_mode = md;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (vout !== 8'h10) begin
      fails++;
      $display("FAIL R1 reset output actual=%h expected=10", vout);
    end
    rst_n = 1'b1;
    mh = 0; mv = 0; my = 0; mu = 0; mw = 0; mo = 0;
    cyc = 2 * tw * tl * frames;
    for (int n = 0; n < cyc; n++) begin
      int f, v, h, ci, k, ph, j, a, o, vd, sum;
      logic [7:0] e;
      logic [31:0] ow;
      string tg;
      @(posedge clk);
      f = (il && mv >= tl / 2) ? 1 : 0;
      v = ((f == 1 ? mv - tl / 2 : mv) >= al) ? 1 : 0;
      ci = -1; h = 0;
      if (mh < 4) ci = mh;
      else if (mh >= 4 + 2 * aw && mh < 8 + 2 * aw) begin ci = mh - 4 - 2 * aw; h = 1; end
      if (ci >= 0) begin
        if (ci == 0) e = 8'hFF;
        else if (ci == 3) e = 8'(128 + f * 64 + v * 32 + h * 16 + (v ^ h) * 8 +
                                 (f ^ h) * 4 + (f ^ v) * 2 + (f ^ v ^ h));
        else e = 8'h00;
        tg = (ci == 3) ? ((f | v) ? "R4" : "R3") : "R2";
      end else if (mh >= 4 && mh < 4 + 2 * aw && v == 0) begin
        k = mh - 4; ph = k % 4; j = k / 4;
        ow = ovf(mo);
        a = int'(ow[31:24]);
        case (ph)
          0: begin vd = int'(uf(mu)); o = int'(ow[15:8]); end
          2: begin vd = int'(vf(mw)); o = int'(ow[7:0]); end
          default: begin vd = int'(yf(my)); o = int'(ow[23:16]); end
        endcase
        if (md == 2'd1) begin
          sum = (a * o + (256 - a) * vd) >> 8;
          e = 8'(sum);
          tg = up ? "R8" : "R9";
        end else if (md == 2'd2) begin
          if (ow[23:16] <= 8'd127 && ow[15:8] >= 8'd64 && ow[7:0] <= 8'd200) e = 8'(vd);
          else e = 8'(o);
          tg = "R10";
        end else begin
          e = 8'(vd);
          tg = (md == 2'd3) ? "R11" : (up ? "R7" : "R6");
        end
        if (ph % 2 == 1) begin
          if (!up || ph == 3) my++;
          if (md == 2'd1 || md == 2'd2) mo++;
        end
        if (ph == 0 && (!up || j % 2 == 1)) mu++;
        if (ph == 2 && (!up || j % 2 == 1)) mw++;
      end else begin
        e = (mh % 2 == 1) ? 8'h10 : 8'h80;
        tg = "R5";
      end
      if (n < 4) tg = "R1";
      qe.push_back(e);
      qr.push_back(tg);
      mh++;
      if (mh == 2 * tw) begin
        mh = 0;
        mv = (mv == tl - 1) ? 0 : mv + 1;
      end
    end
    wait (qe.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    run_cfg(4, 10, 2, 4, 1'b0, 1'b0, 2'd0, 3);   // R6 plain video
    run_cfg(4, 10, 2, 4, 1'b0, 1'b0, 2'd1, 3);   // R9 alpha
    run_cfg(4, 10, 2, 4, 1'b0, 1'b0, 2'd2, 3);   // R10 key
    run_cfg(8, 14, 3, 9, 1'b1, 1'b1, 2'd1, 2);   // R4 R7 R8 interlaced upscale
    run_cfg(8, 12, 2, 3, 1'b0, 1'b1, 2'd3, 3);   // R11 reserved mode
    run_cfg(8, 14, 3, 9, 1'b1, 1'b0, 2'd2, 2);   // R4 R10 interlaced key
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule